// File: doc/BRIEF.md
# Directory Home-Node Coherence Engine

This block is the home-node side of a directory-based cache coherence scheme for a small group of processors connected by a point-to-point network. For every memory block it owns, it holds a directory record made of a state (Uncached, Shared or Exclusive) and a holder mask with one bit per node. Requesting nodes send it read-miss and write-miss requests. The engine works out which remote holders must act, sends each of them its own message, collects their acknowledgements, and then grants the requester either a shared or an exclusive copy. Its final step updates the directory record.

The engine serializes all coherence traffic for its blocks and handles one transaction at a time. A request that arrives while a transaction is open is refused at once with a not-ready reply to its sender. That request does not touch the directory, and the sender is expected to retry. Remote caches, the network and the memory data path sit outside the block.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every directory record is Uncached with an empty holder mask, and no message, reply or refusal output is active.
- R2: A read miss to an Uncached block sends no message. It is answered with a shared grant (rsp_excl = 0), and the record becomes Shared with only the requester as holder.
- R3: A read miss to a Shared block sends no message, is answered with a shared grant, and adds the requester to the holder mask without removing any holder.
- R4: A write miss to a Shared block sends an invalidate (msg_cmd = 1) to every holder except the requester. It is answered with an exclusive grant (rsp_excl = 1), and the record becomes Exclusive with the requester as the only holder.
- R5: The grant is sent only after an acknowledgement has arrived from every node that received a message. A grant never shares a cycle with an outgoing message.
- R6: A read miss to a block held Exclusive by another node sends a fetch (msg_cmd = 2) to that owner alone. It is answered with a shared grant, and the record becomes Shared with both the owner and the requester as holders.
- R7: A write miss to a block held Exclusive by another node sends a fetch-and-invalidate (msg_cmd = 3) to that owner alone. It is answered with an exclusive grant, and the requester becomes the only holder.
- R8: A request that arrives while a transaction is open gets a not-ready reply (nack_valid with nack_dst equal to its source) in the next cycle. It leaves the directory unchanged. A request that arrives while idle is never refused.
- R9: An acknowledgement from a node that has no outstanding message is ignored and does not count toward completing the transaction.
- R10: A request from the node that already holds a block Exclusive sends no message and is answered with an exclusive grant, and the record is unchanged.
- R11: Messages go out one per cycle, one node per message, in increasing node-index order, and each block's record is independent of every other block's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Miss request present this cycle |
| req_src | input | 2 | Requesting node index |
| req_write | input | 1 | 1 = write miss, 0 = read miss |
| req_blk | input | 4 | Block index |
| msg_valid | output | 1 | Coherence message to one remote node |
| msg_dst | output | 2 | Destination node of the message |
| msg_cmd | output | 2 | 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| ack_valid | input | 1 | Acknowledgement from a remote node |
| ack_src | input | 2 | Node sending the acknowledgement |
| rsp_valid | output | 1 | Grant to the requester |
| rsp_dst | output | 2 | Node receiving the grant |
| rsp_blk | output | 4 | Block the grant refers to |
| rsp_excl | output | 1 | 1 exclusive grant, 0 shared grant |
| nack_valid | output | 1 | Not-ready reply to a refused request |
| nack_dst | output | 2 | Node whose request was refused |

## Verification
Requests are issued against records in each of the three states. Three variants separate behaviour that is otherwise easy to confuse: a requester that is itself among the holders, a requester that already owns the block, and several holders at once. Later invalidation masks expose which holders each earlier grant recorded, so a missing or extra holder bit shows up as a wrong set of destinations. Acknowledgements are held back for several cycles, and a stray acknowledgement from an uninvolved node is injected, to tell true completion from early completion. A request sent during an open transaction checks both the refusal and that the refused node never appears in the directory.

// File: rtl/dhc_pkg.sv
package dhc_pkg;

    localparam int unsigned DHC_NODES  = 4;
    localparam int unsigned DHC_BLOCKS = 16;
    localparam int unsigned NODE_W     = $clog2(DHC_NODES);
    localparam int unsigned BLK_W      = $clog2(DHC_BLOCKS);

    typedef logic [NODE_W-1:0]    node_t;
    typedef logic [BLK_W-1:0]     blk_t;
    typedef logic [DHC_NODES-1:0] mask_t;

    typedef enum logic [1:0] {
        DIR_UNCACHED = 2'd0,
        DIR_SHARED   = 2'd1,
        DIR_EXCL     = 2'd2
    } dir_state_e;

    typedef enum logic [1:0] {
        CMD_NONE      = 2'd0,
        CMD_INV       = 2'd1,
        CMD_FETCH     = 2'd2,
        CMD_FETCH_INV = 2'd3
    } coh_cmd_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SEND  = 2'd1,
        PH_WAIT  = 2'd2,
        PH_REPLY = 2'd3
    } phase_e;

    typedef struct packed {
        dir_state_e st;
        mask_t      holders;
    } dir_entry_t;

    typedef struct packed {
        mask_t      targets;
        coh_cmd_e   cmd;
        dir_entry_t next_entry;
        logic       excl;
    } decision_t;

    function automatic mask_t node_bit(node_t n);
        mask_t r;
        r = '0;
        r[n] = 1'b1;
        return r;
    endfunction

    function automatic node_t lowest_node(mask_t m);
        node_t r;
        r = '0;
        for (int i = DHC_NODES - 1; i >= 0; i--) begin
            if (m[i]) r = node_t'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/dir_store.sv
module dir_store
    import dhc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  blk_t       rd_blk,
    output dir_entry_t rd_entry,
    input  logic       wr_en,
    input  blk_t       wr_blk,
    input  dir_entry_t wr_entry
);

    dir_entry_t table_q [DHC_BLOCKS];

    generate
        for (genvar b = 0; b < DHC_BLOCKS; b++) begin : g_rec
            always_ff @(posedge clk) begin
                if (rst) begin
                    table_q[b] <= '{st: DIR_UNCACHED, holders: '0};
                end else if (wr_en && (wr_blk == blk_t'(b))) begin
                    table_q[b] <= wr_entry;
                end
            end
        end
    endgenerate

    assign rd_entry = table_q[rd_blk];

endmodule

// File: rtl/dir_policy.sv
module dir_policy
    import dhc_pkg::*;
(
    input  dir_entry_t cur,
    input  logic       is_write,
    input  node_t      src,
    output decision_t  dec
);

    mask_t src_bit;
    logic  src_owns;

    assign src_bit  = node_bit(src);
    assign src_owns = (cur.holders == src_bit);

    always_comb begin
        dec = '{targets: '0, cmd: CMD_NONE,
                next_entry: '{st: DIR_UNCACHED, holders: '0}, excl: 1'b0};
        if (!is_write) begin
            unique case (cur.st)
                DIR_SHARED: begin
                    dec.next_entry = '{st: DIR_SHARED, holders: cur.holders | src_bit};
                end
                DIR_EXCL: begin
                    if (src_owns) begin
                        dec.next_entry = cur;
                        dec.excl       = 1'b1;
                    end else begin
                        dec.targets    = cur.holders;
                        dec.cmd        = CMD_FETCH;
                        dec.next_entry = '{st: DIR_SHARED, holders: cur.holders | src_bit};
                    end
                end
                default: begin
                    dec.next_entry = '{st: DIR_SHARED, holders: src_bit};
                end
            endcase
        end else begin
            dec.excl       = 1'b1;
            dec.next_entry = '{st: DIR_EXCL, holders: src_bit};
            unique case (cur.st)
                DIR_SHARED: begin
                    dec.targets = cur.holders & ~src_bit;
                    dec.cmd     = CMD_INV;
                end
                DIR_EXCL: begin
                    if (!src_owns) begin
                        dec.targets = cur.holders;
                        dec.cmd     = CMD_FETCH_INV;
                    end
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/msg_seq.sv
module msg_seq
    import dhc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  mask_t    targets,
    input  coh_cmd_e cmd_in,
    input  logic     send_en,
    input  logic     ack_valid,
    input  node_t    ack_src,
    output logic     msg_valid,
    output node_t    msg_dst,
    output coh_cmd_e msg_cmd,
    output logic     send_last,
    output mask_t    ack_pend
);

    mask_t    send_q;
    mask_t    ack_q;
    coh_cmd_e cmd_q;
    mask_t    ack_clr;

    assign msg_valid = send_en && (send_q != '0);
    assign msg_dst   = lowest_node(send_q);
    assign msg_cmd   = cmd_q;
    assign send_last = ((send_q & (send_q - mask_t'(1))) == '0);
    assign ack_clr   = ack_valid ? node_bit(ack_src) : '0;
    assign ack_pend  = ack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            send_q <= '0;
            ack_q  <= '0;
            cmd_q  <= CMD_NONE;
        end else if (load) begin
            send_q <= targets;
            ack_q  <= targets;
            cmd_q  <= cmd_in;
        end else begin
            if (msg_valid) send_q <= send_q & ~node_bit(msg_dst);
            ack_q <= ack_q & ~ack_clr;
        end
    end

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
    import dhc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [NODE_W-1:0]    req_src,
    input  logic                 req_write,
    input  logic [BLK_W-1:0]     req_blk,
    output logic                 msg_valid,
    output logic [NODE_W-1:0]    msg_dst,
    output logic [1:0]           msg_cmd,
    input  logic                 ack_valid,
    input  logic [NODE_W-1:0]    ack_src,
    output logic                 rsp_valid,
    output logic [NODE_W-1:0]    rsp_dst,
    output logic [BLK_W-1:0]     rsp_blk,
    output logic                 rsp_excl,
    output logic                 nack_valid,
    output logic [NODE_W-1:0]    nack_dst
);

    phase_e     phase;
    dir_entry_t cur_entry;
    decision_t  dec;
    logic       accept;
    logic       send_last;
    mask_t      ack_pend;
    coh_cmd_e   seq_cmd;

    node_t      txn_src;
    blk_t       txn_blk;
    logic       txn_excl;
    dir_entry_t txn_next;

    assign accept = req_valid && (phase == PH_IDLE);

    dir_store u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_blk   (req_blk),
        .rd_entry (cur_entry),
        .wr_en    (phase == PH_REPLY),
        .wr_blk   (txn_blk),
        .wr_entry (txn_next)
    );

    dir_policy u_policy (
        .cur      (cur_entry),
        .is_write (req_write),
        .src      (req_src),
        .dec      (dec)
    );

    msg_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .targets   (dec.targets),
        .cmd_in    (dec.cmd),
        .send_en   (phase == PH_SEND),
        .ack_valid (ack_valid),
        .ack_src   (ack_src),
        .msg_valid (msg_valid),
        .msg_dst   (msg_dst),
        .msg_cmd   (seq_cmd),
        .send_last (send_last),
        .ack_pend  (ack_pend)
    );

    assign msg_cmd = seq_cmd;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            txn_src  <= '0;
            txn_blk  <= '0;
            txn_excl <= 1'b0;
            txn_next <= '{st: DIR_UNCACHED, holders: '0};
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        txn_src  <= req_src;
                        txn_blk  <= req_blk;
                        txn_excl <= dec.excl;
                        txn_next <= dec.next_entry;
                        phase    <= (dec.targets != '0) ? PH_SEND : PH_REPLY;
                    end
                end
                PH_SEND: begin
                    if (send_last) phase <= PH_WAIT;
                end
                PH_WAIT: begin
                    if (ack_pend == '0) phase <= PH_REPLY;
                end
                default: begin
                    phase <= PH_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nack_valid <= 1'b0;
            nack_dst   <= '0;
        end else begin
            nack_valid <= req_valid && (phase != PH_IDLE);
            nack_dst   <= req_src;
        end
    end

    assign rsp_valid = (phase == PH_REPLY);
    assign rsp_dst   = txn_src;
    assign rsp_blk   = txn_blk;
    assign rsp_excl  = txn_excl;

endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk
    import dhc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req_valid,
    input  node_t req_src,
    input  logic  msg_valid,
    input  node_t msg_dst,
    input  logic  rsp_valid,
    input  logic  nack_valid,
    input  node_t nack_dst,
    input  logic  busy,
    input  mask_t ack_pend
);

    // R5
    grant_after_acks_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (ack_pend == '0));

    // R5
    grant_msg_apart_chk: assert property (@(posedge clk) disable iff (rst)
        !(rsp_valid && msg_valid));

    // R8
    busy_refused_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && busy) |=> (nack_valid && (nack_dst == $past(req_src))));

    // R8
    idle_not_refused_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> !nack_valid);

    // R11
    msg_awaits_ack_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> ack_pend[msg_dst]);

    // R5
    single_grant_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

endmodule

bind dir_home_ctrl dir_home_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_src    (req_src),
    .msg_valid  (msg_valid),
    .msg_dst    (msg_dst),
    .rsp_valid  (rsp_valid),
    .nack_valid (nack_valid),
    .nack_dst   (nack_dst),
    .busy       (phase != dhc_pkg::PH_IDLE),
    .ack_pend   (ack_pend)
);

// File: tb/dir_home_ctrl_tb.sv
module dir_home_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_src = '0;
    logic       req_write = 1'b0;
    logic [3:0] req_blk = '0;
    logic       msg_valid;
    logic [1:0] msg_dst;
    logic [1:0] msg_cmd;
    logic       ack_valid = 1'b0;
    logic [1:0] ack_src = '0;
    logic       rsp_valid;
    logic [1:0] rsp_dst;
    logic [3:0] rsp_blk;
    logic       rsp_excl;
    logic       nack_valid;
    logic [1:0] nack_dst;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    dir_home_ctrl u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_src(req_src), .req_write(req_write), .req_blk(req_blk),
        .msg_valid(msg_valid), .msg_dst(msg_dst), .msg_cmd(msg_cmd),
        .ack_valid(ack_valid), .ack_src(ack_src),
        .rsp_valid(rsp_valid), .rsp_dst(rsp_dst), .rsp_blk(rsp_blk), .rsp_excl(rsp_excl),
        .nack_valid(nack_valid), .nack_dst(nack_dst)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int low_of(input logic [3:0] m);
        for (int i = 0; i < 4; i++) if (m[i]) return i;
        return 0;
    endfunction

    // One transaction with a well-behaved set of remote nodes.
    task automatic transact(input int src, input bit wr, input int blk,
                            input logic [3:0] exp_mask, input int exp_cmd,
                            input bit exp_excl, input int hold, input string req);
        logic [3:0] seen = '0;
        logic [3:0] pend = '0;
        int  last = -1;
        bit  got  = 1'b0;
        req_valid = 1'b1; req_src = 2'(src); req_write = wr; req_blk = 4'(blk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int cyc = 0; cyc < 100 && !got; cyc++) begin
            ack_valid = 1'b0;
            if (msg_valid) begin
                chk(int'(msg_cmd) == exp_cmd, req, "message command", msg_cmd, exp_cmd);
                // R11: ascending order, one node each
                chk(int'(msg_dst) > last, "R11", "message order", msg_dst, last + 1);
                last = int'(msg_dst);
                seen[msg_dst] = 1'b1;
                pend[msg_dst] = 1'b1;
            end
            if (rsp_valid) begin
                got = 1'b1;
                chk(pend == '0, "R5", "grant before all acks", pend, 0);
                chk(int'(rsp_dst) == src, req, "grant node", rsp_dst, src);
                chk(int'(rsp_blk) == blk, req, "grant block", rsp_blk, blk);
                chk(rsp_excl == exp_excl, req, "grant kind", rsp_excl, exp_excl);
            end else if (cyc >= hold && pend != '0) begin
                ack_valid = 1'b1;
                ack_src   = 2'(low_of(pend));
                pend[low_of(pend)] = 1'b0;
            end
            @(negedge clk);
        end
        ack_valid = 1'b0;
        chk(got, req, "grant seen", got, 1);
        chk(seen == exp_mask, req, "message destinations", seen, exp_mask);
    endtask

    task automatic t_reset;
        chk(!msg_valid && !rsp_valid && !nack_valid, "R1", "outputs idle after reset",
            {msg_valid, rsp_valid, nack_valid}, 0);
        transact(2, 1'b0, 12, 4'b0000, 0, 1'b0, 0, "R1");
    endtask

    task automatic t_read_paths;
        transact(1, 1'b0, 3, 4'b0000, 0, 1'b0, 0, "R2");
        transact(2, 1'b0, 3, 4'b0000, 0, 1'b0, 0, "R3");
    endtask

    task automatic t_write_shared;
        // holders {1,2}; invalidations must wait for delayed acks
        transact(0, 1'b1, 3, 4'b0110, 1, 1'b1, 4, "R4");
        // requester is among the holders: it gets no invalidate
        transact(2, 1'b0, 5, 4'b0000, 0, 1'b0, 0, "R2");
        transact(1, 1'b0, 5, 4'b0000, 0, 1'b0, 0, "R3");
        transact(2, 1'b1, 5, 4'b0010, 1, 1'b1, 1, "R4");
    endtask

    task automatic t_excl_paths;
        // block 3 owned by 0: write miss from 1
        transact(1, 1'b1, 3, 4'b0001, 3, 1'b1, 2, "R7");
        // owned by 1: read miss from 3 fetches from 1
        transact(3, 1'b0, 3, 4'b0010, 2, 1'b0, 0, "R6");
        // both 1 and 3 must now be holders
        transact(0, 1'b1, 3, 4'b1010, 1, 1'b1, 0, "R6");
        // owner re-requests
        transact(0, 1'b1, 3, 4'b0000, 0, 1'b1, 0, "R10");
        transact(0, 1'b0, 3, 4'b0000, 0, 1'b1, 0, "R10");
    endtask

    task automatic t_busy_and_stray;
        bit got = 1'b0;
        transact(1, 1'b0, 7, 4'b0000, 0, 1'b0, 0, "R2");
        transact(2, 1'b0, 7, 4'b0000, 0, 1'b0, 0, "R3");
        req_valid = 1'b1; req_src = 2'd3; req_write = 1'b1; req_blk = 4'd7;
        @(negedge clk);
        chk(msg_valid && msg_dst == 2'd1, "R4", "first invalidate", msg_dst, 1);
        req_src = 2'd0; req_write = 1'b0; req_blk = 4'd9;
        @(negedge clk);
        req_valid = 1'b0;
        chk(nack_valid && nack_dst == 2'd0, "R8", "refusal to node 0", nack_dst, 0);
        chk(msg_valid && msg_dst == 2'd2, "R4", "second invalidate", msg_dst, 2);
        ack_valid = 1'b1; ack_src = 2'd0;
        @(negedge clk);
        ack_valid = 1'b0;
        chk(!nack_valid, "R8", "single refusal", nack_valid, 0);
        for (int i = 0; i < 3; i++) begin
            chk(!rsp_valid, "R9", "no grant after stray ack", rsp_valid, 0);
            @(negedge clk);
        end
        ack_valid = 1'b1; ack_src = 2'd1;
        @(negedge clk);
        chk(!rsp_valid, "R5", "no grant with one ack open", rsp_valid, 0);
        ack_src = 2'd2;
        @(negedge clk);
        ack_valid = 1'b0;
        for (int i = 0; i < 5 && !got; i++) begin
            if (rsp_valid) begin
                got = 1'b1;
                chk(rsp_dst == 2'd3 && rsp_excl, "R4", "grant to node 3", rsp_dst, 3);
            end
            @(negedge clk);
        end
        chk(got, "R5", "grant after last ack", got, 1);
        // refused request left block 9 untouched; other blocks did not leak in
        transact(1, 1'b0, 9, 4'b0000, 0, 1'b0, 0, "R11");
        transact(2, 1'b1, 9, 4'b0010, 1, 1'b1, 0, "R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_paths();
        t_write_shared();
        t_excl_paths();
        t_busy_and_stray();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule